// File: doc/BRIEF.md
# Multicycle Processor Stage Sequencer

This block is the control unit of a small 16-bit multicycle processor. It walks the core through its instruction phases and raises one enable line per cycle toward the datapath. The phases are: instruction fetch, decode, register read, ALU execute, an optional memory access, and register writeback. After writeback it starts the next fetch. The fetch phase is a single cycle. It covers the one cycle of read latency of the on-chip RAM, so the instruction word sits on the RAM output when decode runs.

The sequencer reads the current 5-bit ALU operation field. During the execute cycle it looks at the upper four bits of that field and uses them to decide whether the memory phase runs. Load-from-memory and store-to-memory operations get the extra cycle. Every other operation goes from execute straight to writeback. Memory latency is fixed, so there is no stall or handshake input.

Reset acts on the sequencer only. It parks the sequencer in a quiet state where no enable is active. The register contents elsewhere in the core are untouched, so execution carries on from whatever state they hold.

Top module: `cpu_stage_seq`

## Requirements
- R1: For any operation whose upper four op bits (`alu_op[4:1]`) are neither 4'b1000 nor 4'b1001, the enables run fetch, decode, register read, ALU, register write, one per cycle, and the following cycle is fetch again.
- R2: When `alu_op[4:1]` equals 4'b1000 (memory read) during the ALU cycle, the memory enable is active in the next cycle and register write in the cycle after it.
- R3: When `alu_op[4:1]` equals 4'b1001 (memory write) during the ALU cycle, the memory enable is active in the next cycle and register write in the cycle after it.
- R4: Bit 0 of `alu_op` has no effect on whether the memory cycle is taken.
- R5: `alu_op` is sampled only in the ALU cycle; its value in any other cycle does not change the enable sequence.
- R6: Out of reset, exactly one of the six enables is high in every cycle.
- R7: Reset is synchronous and active low: after a rising clock edge with `rst_n` low, all six enables are low, including when reset arrives in the middle of an instruction, and they stay low while reset is held.
- R8: On the first rising edge at which `rst_n` is high after reset, the sequencer enters fetch, so `en_fetch` is the first enable that is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the sequencer |
| alu_op | input | 5 | Current ALU operation field; upper four bits are the opcode |
| en_fetch | output | 1 | Instruction fetch enable (RAM addressed by the program counter) |
| en_decode | output | 1 | Instruction decoder enable |
| en_regread | output | 1 | Register file read enable |
| en_alu | output | 1 | ALU execute enable |
| en_mem | output | 1 | Memory access enable (read or write operations only) |
| en_regwrite | output | 1 | Register file write enable |

## Verification
The assertions assume that `rst_n` is driven to a known level from time zero. They also assume that `alu_op` is stable around the rising edge that ends the ALU cycle, because that edge is the only place the opcode is used. The stimulus meets both assumptions: it changes `alu_op` and `rst_n` only on falling edges, and it starts with reset held low. Separate sequences hold a decoy opcode in every cycle except the ALU cycle. Another sequence drops reset in the middle of an instruction.

// File: rtl/cpu_seq_pkg.sv
// Package: cpu_seq_pkg
// Shared constants and the stage type for the stage sequencer.
// Assumes the opcode occupies the upper OPC_W bits of the ALU op field.
package cpu_seq_pkg;

    localparam int OP_W   = 5;   // width of the ALU operation field
    localparam int OPC_W  = 4;   // width of the opcode inside it
    localparam int NUM_EN = 6;   // number of stage enables

    localparam logic [OPC_W-1:0] OPC_MEM_RD = 4'b1000;
    localparam logic [OPC_W-1:0] OPC_MEM_WR = 4'b1001;

    // Enable bit positions; position k is raised by stage value k+1
    localparam int EN_FETCH   = 0;
    localparam int EN_DECODE  = 1;
    localparam int EN_REGREAD = 2;
    localparam int EN_ALU     = 3;
    localparam int EN_MEM     = 4;
    localparam int EN_REGWR   = 5;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_DEC   = 3'd2,
        ST_REGRD = 3'd3,
        ST_EXEC  = 3'd4,
        ST_MEM   = 3'd5,
        ST_WB    = 3'd6
    } stage_e;

endpackage

// File: rtl/seq_memop_detect.sv
// Module: seq_memop_detect
// Flags an ALU operation that needs the memory stage, i.e. whose upper
// opcode bits match the memory read or memory write opcode.
// Assumes OP_W >= OPC_W; the bits below the opcode do not matter.
module seq_memop_detect
    import cpu_seq_pkg::*;
#(
    parameter int OP_W_P = OP_W
) (
    input  logic [OP_W_P-1:0] alu_op,
    output logic              needs_mem
);

    localparam int LOW_W = OP_W_P - OPC_W;

    logic [OP_W_P-1:0] opc_field;

    // Align the opcode to bit 0 and compare it with both memory opcodes
    always_comb begin
        opc_field = alu_op >> LOW_W;
        needs_mem = (opc_field == OP_W_P'(OPC_MEM_RD)) ||
                    (opc_field == OP_W_P'(OPC_MEM_WR));
    end

endmodule

// File: rtl/seq_stage_fsm.sv
// Module: seq_stage_fsm
// Stage register and next-stage logic. Walks fetch, decode, register
// read, execute, an optional memory stage, then writeback, and loops.
// Assumes needs_mem is valid in the execute cycle; it is ignored in
// every other stage. Reset is synchronous and active low.
module seq_stage_fsm
    import cpu_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   needs_mem,
    output stage_e stage
);

    stage_e stage_q;
    stage_e stage_d;

    // Next-stage selection; memory stage taken only from execute
    always_comb begin
        unique case (stage_q)
            ST_IDLE:  stage_d = ST_FETCH;
            ST_FETCH: stage_d = ST_DEC;
            ST_DEC:   stage_d = ST_REGRD;
            ST_REGRD: stage_d = ST_EXEC;
            ST_EXEC:  stage_d = needs_mem ? ST_MEM : ST_WB;
            ST_MEM:   stage_d = ST_WB;
            ST_WB:    stage_d = ST_FETCH;
            default:  stage_d = ST_IDLE;
        endcase
    end

    // Stage register with synchronous active-low reset to the quiet state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= ST_IDLE;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign stage = stage_q;

endmodule

// File: rtl/seq_enable_decode.sv
// Module: seq_enable_decode
// Turns the stage code into one-hot enables; enable k is high for stage
// value k+1 and every enable is low in the idle stage.
// Assumes the stage values of cpu_seq_pkg are numbered in enable order.
module seq_enable_decode
    import cpu_seq_pkg::*;
#(
    parameter int N_EN = NUM_EN
) (
    input  stage_e          stage,
    output logic [N_EN-1:0] en
);

    for (genvar k = 0; k < N_EN; k++) begin : g_en
        // One comparator per enable line
        assign en[k] = (stage == stage_e'(k + 1));
    end

endmodule

// File: rtl/cpu_stage_seq.sv
// Module: cpu_stage_seq
// Top of the stage sequencer of a small multicycle processor. Drives one
// enable per cycle to the datapath and inserts the memory stage for the
// memory read and memory write opcodes.
// Assumes fixed one-cycle memory latency (no stall input) and that only
// this sequencer is reset by rst_n.
module cpu_stage_seq
    import cpu_seq_pkg::*;
#(
    parameter int OP_W_P = OP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W_P-1:0] alu_op,
    output logic              en_fetch,
    output logic              en_decode,
    output logic              en_regread,
    output logic              en_alu,
    output logic              en_mem,
    output logic              en_regwrite
);

    logic              needs_mem;
    stage_e            stage;
    logic [NUM_EN-1:0] en_vec;

    seq_memop_detect #(
        .OP_W_P (OP_W_P)
    ) memop_i (
        .alu_op    (alu_op),
        .needs_mem (needs_mem)
    );

    seq_stage_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .needs_mem (needs_mem),
        .stage     (stage)
    );

    seq_enable_decode #(
        .N_EN (NUM_EN)
    ) dec_i (
        .stage (stage),
        .en    (en_vec)
    );

    assign en_fetch    = en_vec[EN_FETCH];
    assign en_decode   = en_vec[EN_DECODE];
    assign en_regread  = en_vec[EN_REGREAD];
    assign en_alu      = en_vec[EN_ALU];
    assign en_mem      = en_vec[EN_MEM];
    assign en_regwrite = en_vec[EN_REGWR];

endmodule

// File: rtl/cpu_stage_seq_chk.sv
// Module: cpu_stage_seq_chk
// Port-level protocol checks for cpu_stage_seq, attached with bind.
// Assumes rst_n is known from time zero.
module cpu_stage_seq_chk
    import cpu_seq_pkg::*;
#(
    parameter int OP_W_P = OP_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [OP_W_P-1:0] alu_op,
    input logic              en_fetch,
    input logic              en_decode,
    input logic              en_regread,
    input logic              en_alu,
    input logic              en_mem,
    input logic              en_regwrite
);

    localparam int LOW_W = OP_W_P - OPC_W;

    logic [NUM_EN-1:0] ens;
    logic [OP_W_P-1:0] opc;
    logic              is_rd;
    logic              is_wr;

    assign ens   = {en_regwrite, en_mem, en_alu, en_regread, en_decode, en_fetch};
    assign opc   = alu_op >> LOW_W;
    assign is_rd = (opc == OP_W_P'(OPC_MEM_RD));
    assign is_wr = (opc == OP_W_P'(OPC_MEM_WR));

    assert_fetch_to_decode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        en_fetch |=> en_decode);
    assert_decode_to_regread_R1: assert property (@(posedge clk) disable iff (!rst_n)
        en_decode |=> en_regread);
    assert_regread_to_alu_R1: assert property (@(posedge clk) disable iff (!rst_n)
        en_regread |=> en_alu);
    assert_alu_skip_mem_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (en_alu && !is_rd && !is_wr) |=> en_regwrite);
    assert_wb_to_fetch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        en_regwrite |=> en_fetch);
    assert_read_enters_mem_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_alu && is_rd) |=> en_mem);
    assert_write_enters_mem_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_alu && is_wr) |=> en_mem);
    assert_mem_to_wb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        en_mem |=> en_regwrite);
    assert_one_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n)) |-> $onehot(ens));
    assert_reset_quiet_R7: assert property (@(posedge clk)
        !rst_n |=> (ens == '0));
    assert_fetch_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |=> en_fetch);

endmodule

bind cpu_stage_seq cpu_stage_seq_chk #(.OP_W_P(OP_W_P)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .alu_op      (alu_op),
    .en_fetch    (en_fetch),
    .en_decode   (en_decode),
    .en_regread  (en_regread),
    .en_alu      (en_alu),
    .en_mem      (en_mem),
    .en_regwrite (en_regwrite)
);

// File: tb/cpu_stage_seq_tb_top.sv
// Bench for cpu_stage_seq: a behavioural reference builds the expected
// stage list of each instruction in a queue and compares it every cycle.
module cpu_stage_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    logic       clk;
    logic       rst_n;
    logic [4:0] alu_op;
    logic       en_fetch, en_decode, en_regread, en_alu, en_mem, en_regwrite;

    int n_vec;
    int n_bad;
    bit done;

    cpu_stage_seq dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .alu_op      (alu_op),
        .en_fetch    (en_fetch),
        .en_decode   (en_decode),
        .en_regread  (en_regread),
        .en_alu      (en_alu),
        .en_mem      (en_mem),
        .en_regwrite (en_regwrite)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    // Stage numbers: 0 none, 1 fetch, 2 decode, 3 regread, 4 alu, 5 mem, 6 regwrite
    function automatic logic [5:0] exp_vec(input int stg);
        return (stg == 0) ? 6'b0 : (6'b1 << (stg - 1));
    endfunction

    task automatic check_stage(input int stg, input string req);
        logic [5:0] got;
        got = {en_regwrite, en_mem, en_alu, en_regread, en_decode, en_fetch};
        n_vec++;
        if (got !== exp_vec(stg)) begin
            n_bad++;
            $display("FAIL %s: enables actual=%b expected=%b", req, got, exp_vec(stg));
        end
        if (stg != 0) begin
            n_vec++;
            if ($countones(got) != 1) begin
                n_bad++;
                $display("FAIL R6: active enables actual=%0d expected=1", $countones(got));
            end
        end
    endtask

    // Runs one instruction; op_exec is driven only across the ALU cycle
    task automatic run_instr(input logic [4:0] op_exec, input logic [4:0] op_noise,
                             input string req, input int stop_after);
        int  q[$];
        bit  mem;
        mem = (op_exec[4:1] == 4'b1000) || (op_exec[4:1] == 4'b1001);
        q = '{1, 2, 3, 4};
        if (mem) q.push_back(5);
        q.push_back(6);
        alu_op = op_noise;
        for (int i = 0; i < q.size(); i++) begin
            if (stop_after >= 0 && i >= stop_after) break;
            @(negedge clk);
            check_stage(q[i], req);
            if (q[i] == 3) alu_op = op_exec;
            if (i == 4) alu_op = op_noise;
        end
    endtask

    initial begin
        n_vec  = 0;
        n_bad  = 0;
        done   = 1'b0;
        rst_n  = 1'b0;
        alu_op = 5'b00000;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_stage(0, "R7");
        end
        rst_n = 1'b1;
        run_instr(5'b00000, 5'b00000, "R8", -1);
        run_instr(5'b00110, 5'b00110, "R1", -1);
        run_instr(5'b10000, 5'b10000, "R2", -1);
        run_instr(5'b10010, 5'b10010, "R3", -1);
        run_instr(5'b01110, 5'b01110, "R1", -1);
        run_instr(5'b10100, 5'b10100, "R1", -1);
        run_instr(5'b11110, 5'b11110, "R1", -1);
        run_instr(5'b10001, 5'b10001, "R4", -1);
        run_instr(5'b10011, 5'b10011, "R4", -1);
        run_instr(5'b00010, 5'b10000, "R5", -1);
        run_instr(5'b10000, 5'b00100, "R5", -1);
        run_instr(5'b10010, 5'b10010, "R3", -1);
        run_instr(5'b10000, 5'b10000, "R7", 2);
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_stage(0, "R7");
        end
        rst_n = 1'b1;
        run_instr(5'b10010, 5'b10010, "R8", -1);
        run_instr(5'b01000, 5'b01000, "R1", -1);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * WD_CYCLES);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule